// File: doc/BRIEF.md
# SNR-Indexed LSB Precision Controller

This block converts a quantized input-quality step into a set of per-bit enables for the low-order flip-flops of a multi-stage fixed-point datapath. The enables go to clock-gating cells or hold enables. A flip-flop whose enable is low keeps its contents and does not toggle. Downstream logic treats that bit as zero. Switching off low-order bits when the incoming signal has quality to spare lowers dynamic power, and the clock rate stays the same.

A small table holds one enable row per quality step. Software or a sequencer loads the table through an address/data/write-enable port. Every row comes out of reset at full precision. The table accepts only rows in which each stage's field switches off a run of bits that starts at the least significant bit and leaves the top bit enabled. Any other row is refused and flagged.

The step index and its valid flag are registered first. The selected row reaches the enable outputs only on a stage-aligned update strobe, so a data sample never sees two precision settings at once. An index past the last row uses the last row. A measurement marked invalid forces full precision.

Top module: `lsb_prec_ctrl`

## Requirements
- R1: After reset, `bit_en` is all ones, `tbl_reject` is low, and every table row holds all ones.
- R2: A write with `tbl_we` high, `tbl_addr` below `NUM_STEPS` and an acceptable row stores `tbl_wdata` in that row. A later selection of that row returns the stored value.
- R3: `snr_idx` and `snr_valid` are captured on every clock edge. `bit_en` is loaded only on an edge where `upd_strobe` is high, using the index and valid flag captured on the previous edge. At all other times `bit_en` holds, even if the index or the table changes.
- R4: A captured index of `NUM_STEPS` or more selects row `NUM_STEPS-1`.
- R5: When the captured `snr_valid` is low, the strobe loads all ones, whatever the table holds.
- R6: A row is refused if any stage field is not thermometer-shaped (a zero above a one) or has its top bit at zero. A refused row leaves the table unchanged, and `tbl_reject` is high in the cycle after the write edge.
- R7: A write to an address of `NUM_STEPS` or more changes no row and raises `tbl_reject` in the same way as R6.
- R8: Stage s owns bits [6s+5:6s] of a row and of `bit_en`, with bit 6s as its least significant bit. Every field of `bit_en` always has its top bit set and ones only in one run that reaches that top bit.
- R9: `tbl_reject` is low in the cycle after an edge with no write or with an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 4 | Table row address (quality step) |
| tbl_wdata | input | 24 | Row to store, one bit per controlled flip-flop |
| tbl_reject | output | 1 | Previous write was refused (bad shape or address) |
| snr_idx | input | 4 | Quantized input-quality step index |
| snr_valid | input | 1 | Quality measurement is valid |
| upd_strobe | input | 1 | Stage-aligned update point for the enables |
| bit_en | output | 24 | Per-bit enables, high means active |

## Verification
The bench checks that changing the index or rewriting the active row between strobes leaves `bit_en` unchanged. A design that loads the enables without waiting for the strobe would mix precision settings inside one sample. Indices past the last row must return the last row; a design that does not saturate would read an undefined row. An invalid measurement must give full precision even when the table holds a trimmed row. Refused rows are tested with a hole inside a field and with an all-zero field, and a write to an out-of-range address is also tested. A design that accepts any of these would store a row that switches off top bits, and a design that drops the flag would hide the misconfiguration.

// File: rtl/lpc_row_check.sv
module lpc_row_check #(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned STAGE_BITS = 6,
  localparam int unsigned EN_W = NUM_STAGES * STAGE_BITS
) (
  input  logic [EN_W-1:0] row,
  output logic            row_ok
);
  logic [NUM_STAGES-1:0] field_ok;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    logic [STAGE_BITS-1:0] fld, off, off_inc;
    assign fld     = row[s*STAGE_BITS +: STAGE_BITS];
    assign off     = ~fld;
    assign off_inc = off + 1'b1;
    // disabled bits must form a run from the LSB; MSB must stay on
    assign field_ok[s] = fld[STAGE_BITS-1] && ((off & off_inc) == '0);
  end

  assign row_ok = &field_ok;
endmodule

// File: rtl/lpc_idx_reg.sv
module lpc_idx_reg #(
  parameter int unsigned NUM_STEPS = 11,
  parameter int unsigned IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx_in,
  input  logic             valid_in,
  output logic [IDX_W-1:0] idx_q,
  output logic             valid_q
);
  localparam logic [IDX_W:0]   STEPS_W = (IDX_W+1)'(NUM_STEPS);
  localparam logic [IDX_W-1:0] LAST    = IDX_W'(NUM_STEPS - 1);

  logic [IDX_W-1:0] idx_sat;
  assign idx_sat = ({1'b0, idx_in} >= STEPS_W) ? LAST : idx_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      idx_q   <= idx_sat;
      valid_q <= valid_in;
    end
  end

  // R4: registered index never points past the last row
  a_r4_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    {1'b0, idx_q} < STEPS_W);
endmodule

// File: rtl/lpc_table.sv
module lpc_table #(
  parameter int unsigned NUM_STEPS = 11,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned EN_W      = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [EN_W-1:0]  wdata,
  input  logic             shape_ok,
  input  logic [IDX_W-1:0] raddr,
  output logic [EN_W-1:0]  rdata,
  output logic             reject
);
  localparam logic [IDX_W:0] STEPS_W = (IDX_W+1)'(NUM_STEPS);

  logic [EN_W-1:0] mem [NUM_STEPS];
  logic addr_ok, wr_ok;

  assign addr_ok = {1'b0, waddr} < STEPS_W;
  assign wr_ok   = addr_ok && shape_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_STEPS; i++) mem[i] <= '1;
      reject <= 1'b0;
    end else begin
      if (we && wr_ok) mem[waddr] <= wdata;
      reject <= we && !wr_ok;
    end
  end

  assign rdata = ({1'b0, raddr} < STEPS_W) ? mem[raddr] : '1;

  // R6/R7: refused write is flagged on the following cycle
  a_r6_flag_refused: assert property (@(posedge clk) disable iff (rst)
    we && !(addr_ok && shape_ok) |=> reject);
  // R9: flag stays low without a refused write
  a_r9_flag_quiet: assert property (@(posedge clk) disable iff (rst)
    !(we && !(addr_ok && shape_ok)) |=> !reject);
endmodule

// File: rtl/lsb_prec_ctrl.sv
module lsb_prec_ctrl #(
  parameter int unsigned NUM_STEPS  = 11,
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned STAGE_BITS = 6,
  localparam int unsigned IDX_W = $clog2(NUM_STEPS),
  localparam int unsigned EN_W  = NUM_STAGES * STAGE_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_addr,
  input  logic [EN_W-1:0]  tbl_wdata,
  output logic             tbl_reject,
  input  logic [IDX_W-1:0] snr_idx,
  input  logic             snr_valid,
  input  logic             upd_strobe,
  output logic [EN_W-1:0]  bit_en
);
  logic             shape_ok;
  logic [IDX_W-1:0] idx_q;
  logic             valid_q;
  logic [EN_W-1:0]  row_sel;

  lpc_row_check #(.NUM_STAGES(NUM_STAGES), .STAGE_BITS(STAGE_BITS)) u_chk (
    .row(tbl_wdata), .row_ok(shape_ok));

  lpc_idx_reg #(.NUM_STEPS(NUM_STEPS), .IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst(rst), .idx_in(snr_idx), .valid_in(snr_valid),
    .idx_q(idx_q), .valid_q(valid_q));

  lpc_table #(.NUM_STEPS(NUM_STEPS), .IDX_W(IDX_W), .EN_W(EN_W)) u_tbl (
    .clk(clk), .rst(rst), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
    .shape_ok(shape_ok), .raddr(idx_q), .rdata(row_sel), .reject(tbl_reject));

  always_ff @(posedge clk) begin
    if (rst)             bit_en <= '1;
    else if (upd_strobe) bit_en <= valid_q ? row_sel : '1;
  end

  // R3: enables move only on a strobe edge
  a_r3_hold_between_strobes: assert property (@(posedge clk) disable iff (rst)
    !upd_strobe |=> $stable(bit_en));
  // R5: invalid measurement gives full precision
  a_r5_invalid_full: assert property (@(posedge clk) disable iff (rst)
    upd_strobe && !valid_q |=> (&bit_en));

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_shape
    logic [STAGE_BITS-1:0] fld, fld_shl;
    assign fld     = bit_en[s*STAGE_BITS +: STAGE_BITS];
    assign fld_shl = fld << 1;
    // R8: each output field is a run of ones reaching its MSB
    a_r8_field_shape: assert property (@(posedge clk) disable iff (rst)
      fld[STAGE_BITS-1] && ($countones(fld ^ fld_shl) == 1));
  end
endmodule

// File: tb/lsb_prec_ctrl_tb.sv
module lsb_prec_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int STEPS = 11;
  localparam int SB = 6;
  localparam int NST = 4;
  localparam int W = SB * NST;

  logic clk = 0, rst = 1;
  logic tbl_we = 0, snr_valid = 0, upd_strobe = 0;
  logic [3:0] tbl_addr = 0, snr_idx = 0;
  logic [W-1:0] tbl_wdata = 0;
  logic tbl_reject;
  logic [W-1:0] bit_en;
  logic [W-1:0] exp_tbl [STEPS];
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsb_prec_ctrl u_dut (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .tbl_reject(tbl_reject), .snr_idx(snr_idx),
    .snr_valid(snr_valid), .upd_strobe(upd_strobe), .bit_en(bit_en));

  function automatic logic [W-1:0] mk(int d0, int d1, int d2, int d3);
    logic [W-1:0] r;
    int d [4];
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    for (int s = 0; s < NST; s++)
      for (int b = 0; b < SB; b++)
        r[s*SB + b] = (b >= d[s]);
    return r;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [W-1:0] d);
    @(negedge clk); tbl_we = 1; tbl_addr = a; tbl_wdata = d;
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic sel(logic [3:0] i, logic v);
    @(negedge clk); snr_idx = i; snr_valid = v;
    @(negedge clk); upd_strobe = 1;
    @(negedge clk); upd_strobe = 0;
  endtask

  task automatic t_reset;
    chk("R1 reset bit_en", bit_en, '1);
    chk("R1 reset reject", W'(tbl_reject), W'(0));
    sel(0, 1);  chk("R1 row0 ones", bit_en, '1);
    sel(10, 1); chk("R1 row10 ones", bit_en, '1);
  endtask

  task automatic t_write_read;
    exp_tbl[3] = mk(1, 2, 3, 0);
    wr(3, exp_tbl[3]);
    chk("R9 accepted write no flag", W'(tbl_reject), W'(0));
    exp_tbl[7] = mk(5, 4, 0, 2);
    wr(7, exp_tbl[7]);
    sel(3, 1); chk("R2 R8 row3", bit_en, exp_tbl[3]);
    sel(7, 1); chk("R2 R8 row7", bit_en, exp_tbl[7]);
  endtask

  task automatic t_hold;
    sel(3, 1);
    @(negedge clk); snr_idx = 7;
    repeat (3) @(negedge clk);
    chk("R3 hold on index change", bit_en, exp_tbl[3]);
    wr(3, mk(0, 0, 0, 1));
    repeat (2) @(negedge clk);
    chk("R3 hold on row rewrite", bit_en, exp_tbl[3]);
    exp_tbl[3] = mk(0, 0, 0, 1);
    sel(3, 1); chk("R3 new row after strobe", bit_en, exp_tbl[3]);
  endtask

  task automatic t_saturate;
    exp_tbl[10] = mk(3, 3, 2, 5);
    wr(10, exp_tbl[10]);
    sel(13, 1); chk("R4 idx13 -> last", bit_en, exp_tbl[10]);
    sel(7, 1);
    sel(15, 1); chk("R4 idx15 -> last", bit_en, exp_tbl[10]);
  endtask

  task automatic t_invalid;
    sel(7, 1);
    sel(7, 0); chk("R5 invalid full precision", bit_en, '1);
  endtask

  task automatic t_reject;
    logic [W-1:0] holey;
    holey = exp_tbl[7];
    holey[SB +: SB] = 6'b110101;
    wr(7, holey);
    chk("R6 hole flagged", W'(tbl_reject), W'(1));
    sel(7, 1); chk("R6 row kept after hole", bit_en, exp_tbl[7]);
    wr(7, mk(0, 0, 6, 0));
    chk("R6 zero field flagged", W'(tbl_reject), W'(1));
    sel(7, 1); chk("R6 row kept after zero field", bit_en, exp_tbl[7]);
    @(negedge clk);
    chk("R9 flag clears", W'(tbl_reject), W'(0));
  endtask

  task automatic t_addr_oob;
    wr(12, mk(1, 1, 1, 1));
    chk("R7 oob flagged", W'(tbl_reject), W'(1));
    sel(10, 1); chk("R7 last row unchanged", bit_en, exp_tbl[10]);
  endtask

  initial begin
    for (int i = 0; i < STEPS; i++) exp_tbl[i] = '1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_hold();
    t_saturate();
    t_invalid();
    t_reject();
    t_addr_oob();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule